// File: doc/BRIEF.md
# Serial Boot Entry and Autobaud Command Decoder

This block sits between the board-level boot pins and a downstream loader engine. It watches the hold-reset level and an active-low boot-request level, and it raises a load-mode flag when both are asserted together. The flag stays set for as long as the hold-reset level stays high. When the two mode-select levels both read high, the block arms serial detection. Four receivers then watch the raw serial line, each at a different bit rate. The first receiver that frames a carriage-return byte (0x0D) fixes the link rate.

Once the rate is locked, only the receiver for that rate stays active. Each byte it frames is matched against the fixed loader command alphabet. A match produces a one-cycle, one-hot command strobe. Any other byte, or any byte with a bad stop bit, produces a one-cycle error pulse. Hex parsing and memory writes belong to the downstream engine.

Top module: `sboot_entry`

## Requirements
- R1: While `rstN` is low, `loadMode`, `rateLocked`, `rateIdx`, `cmdStrobe` and `errPulse` are all zero.
- R2: `loadMode` sets three cycles after `holdResetIn` is high and `bootPullN` is low together. It then stays set while `holdResetIn` stays high, even after `bootPullN` returns high. With `bootPullN` high it does not set.
- R3: Three cycles after `holdResetIn` goes low, `loadMode` and `rateLocked` clear and `rateIdx` returns to 0.
- R4: Rate hunting runs only while `loadMode` is set and both `modeSelA` and `modeSelB` are high. A carriage return sent while either select is low leaves `rateLocked` clear.
- R5: Frames are 8N1, least significant bit first, sampled at mid-bit. The rate index codes are: 0 for `BASE_DIV` clock cycles per bit (9600 bps), 1 for 4×`BASE_DIV` (2400), 2 for 8×`BASE_DIV` (1200) and 3 for 32×`BASE_DIV` (300).
- R6: Before lock, the first 0x0D framed with a high stop bit on rate k sets `rateLocked` and sets `rateIdx` to k, one cycle after its stop-bit sample. Any other byte before lock is ignored and raises no error. If two rates complete a carriage return in the same cycle, the lower index wins. The locked index holds until `loadMode` clears.
- R7: After lock, a valid byte on the locked rate pulses exactly one `cmdStrobe` bit for one cycle. The bits are: C→0, D→1, F→2, G→3, K→4, L→5, P→6, R→7, T→8, U→9, V→10, W→11, Z→12.
- R8: Lower-case command letters give the same strobe as their upper-case form.
- R9: After lock, a byte with a valid stop bit that is not a command letter (0x0D included) pulses `errPulse` for one cycle and produces no strobe.
- R10: After lock, a byte whose stop bit samples low pulses `errPulse` for one cycle and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low logic reset |
| holdResetIn | input | 1 | Board hold-reset level, active high |
| bootPullN | input | 1 | Boot request level, active low |
| modeSelA | input | 1 | First load-mode select level; must be high for serial loading |
| modeSelB | input | 1 | Second load-mode select level; must be high for serial loading |
| serialRx | input | 1 | Raw asynchronous receive line, idle high |
| loadMode | output | 1 | Load mode entered |
| rateLocked | output | 1 | Link rate found |
| rateIdx | output | 2 | Locked rate index (R5 codes) |
| cmdStrobe | output | 13 | One-hot command strobes (R7 bit map) |
| errPulse | output | 1 | One-cycle error on an unknown or badly framed byte |

## Verification
Pin-level changes reach `loadMode`, `rateLocked` and `rateIdx` exactly three cycles after they are driven: two synchronizer stages, then the control register. A frame whose start bit is driven at cycle c, on a rate with P cycles per bit, produces its lock, strobe or error in cycle c + 4 + P/2 + 9P. That is the stop-bit sample plus one control register. The bench's reference model schedules each predicted effect at exactly that cycle and compares every output on every falling edge. A pulse one cycle early or late therefore fails the comparison, as does a missing or extra pulse.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

  localparam int RATE_COUNT = 4;
  localparam int RATE_SEL_W = $clog2(RATE_COUNT);
  localparam int NUM_CMDS   = 13;
  localparam logic [7:0] CR_CHAR = 8'h0D;

  // Bit-period multiplier relative to the fastest candidate rate.
  function automatic int rateMult(input int idx);
    case (idx)
      0:       return 1;
      1:       return 4;
      2:       return 8;
      default: return 32;
    endcase
  endfunction

  typedef enum logic [3:0] {
    CMD_CRC, CMD_DUMP, CMD_FILL, CMD_GETP, CMD_KEY, CMD_LOADHEX, CMD_PUTP,
    CMD_RDCFG, CMD_TRACE, CMD_UNLOCK, CMD_VERIFY, CMD_WRCFG, CMD_LOCK
  } cmdId_t;

  typedef struct packed {
    logic   hit;
    cmdId_t id;
  } cmdDec_t;

  // Control to datapath: which receivers run, and which one is selected.
  typedef struct packed {
    logic [RATE_COUNT-1:0] rxEnable;
    logic [RATE_SEL_W-1:0] selIdx;
  } dpCtrl_t;

  // Datapath to control: synchronized pins and per-byte strobes.
  typedef struct packed {
    logic [RATE_COUNT-1:0] crHit;
    logic                  selDone;
    logic                  selOk;
    logic                  selIsCmd;
    logic [NUM_CMDS-1:0]   selCmd;
    logic                  rstS;
    logic                  pullNS;
    logic                  selAS;
    logic                  selBS;
  } dpStat_t;

  function automatic cmdDec_t decodeCmd(input logic [7:0] ch);
    cmdDec_t    r;
    logic [7:0] up;
    up    = (ch >= 8'h61 && ch <= 8'h7A) ? (ch & 8'hDF) : ch;
    r.hit = 1'b1;
    r.id  = CMD_CRC;
    case (up)
      8'h43:   r.id = CMD_CRC;
      8'h44:   r.id = CMD_DUMP;
      8'h46:   r.id = CMD_FILL;
      8'h47:   r.id = CMD_GETP;
      8'h4B:   r.id = CMD_KEY;
      8'h4C:   r.id = CMD_LOADHEX;
      8'h50:   r.id = CMD_PUTP;
      8'h52:   r.id = CMD_RDCFG;
      8'h54:   r.id = CMD_TRACE;
      8'h55:   r.id = CMD_UNLOCK;
      8'h56:   r.id = CMD_VERIFY;
      8'h57:   r.id = CMD_WRCFG;
      8'h5A:   r.id = CMD_LOCK;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sboot_rx.sv
module sboot_rx #(
  parameter int PERIOD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       rxS,
  output logic       byteDone,
  output logic       byteOk,
  output logic [7:0] byteData
);

  localparam int CNT_W = $clog2(PERIOD);
  localparam int HALF  = PERIOD / 2;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rxState_t;

  rxState_t         rxSt;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitCnt;
  logic [7:0]       shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt     <= RX_IDLE;
      cnt      <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      byteDone <= 1'b0;
      byteOk   <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!en) begin
        rxSt <= RX_IDLE;
      end else begin
        case (rxSt)
          RX_IDLE: if (!rxS) begin
            rxSt <= RX_START;
            cnt  <= CNT_W'(HALF - 1);
          end
          RX_START: if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!rxS) begin
            rxSt   <= RX_DATA;
            cnt    <= CNT_W'(PERIOD - 1);
            bitCnt <= '0;
          end else begin
            rxSt <= RX_IDLE;
          end
          RX_DATA: if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else begin
            shReg <= {rxS, shReg[7:1]};
            cnt   <= CNT_W'(PERIOD - 1);
            if (bitCnt == 3'd7) rxSt <= RX_STOP;
            else bitCnt <= bitCnt + 3'd1;
          end
          RX_STOP: if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else begin
            byteDone <= 1'b1;
            byteOk   <= rxS;
            rxSt     <= rxS ? RX_IDLE : RX_BREAK;
          end
          RX_BREAK: if (rxS) rxSt <= RX_IDLE;
          default:  rxSt <= RX_IDLE;
        endcase
      end
    end
  end

  assign byteData = shReg;

  // R4: a held-off receiver never reports a byte.
  p_rx_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !byteDone);
  // R5: a frame completes as a single-cycle report.
  p_rx_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

endmodule

// File: rtl/sboot_datapath.sv
module sboot_datapath
  import sboot_pkg::*;
#(
  parameter int BASE_DIV = 1152
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    holdResetIn,
  input  logic    bootPullN,
  input  logic    modeSelA,
  input  logic    modeSelB,
  input  logic    serialRx,
  input  dpCtrl_t ctl,
  output dpStat_t st
);

  localparam int SYNC_W = 5;
  // Order: {serialRx, holdResetIn, bootPullN, modeSelA, modeSelB}
  localparam logic [SYNC_W-1:0] SYNC_RST = 5'b10111;

  logic [SYNC_W-1:0] syncA, syncB;
  logic              rxS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= SYNC_RST;
      syncB <= SYNC_RST;
    end else begin
      syncA <= {serialRx, holdResetIn, bootPullN, modeSelA, modeSelB};
      syncB <= syncA;
    end
  end

  assign rxS = syncB[4];

  logic [RATE_COUNT-1:0] rxDone, rxOk;
  logic [7:0]            rxData [RATE_COUNT];

  for (genvar k = 0; k < RATE_COUNT; k++) begin : g_rate
    sboot_rx #(.PERIOD(BASE_DIV * rateMult(k))) u_rx (
      .clk      (clk),
      .rstN     (rstN),
      .en       (ctl.rxEnable[k]),
      .rxS      (rxS),
      .byteDone (rxDone[k]),
      .byteOk   (rxOk[k]),
      .byteData (rxData[k])
    );
    assign st.crHit[k] = rxDone[k] & rxOk[k] & (rxData[k] == CR_CHAR);
  end

  cmdDec_t selDec;

  always_comb begin
    selDec      = decodeCmd(rxData[ctl.selIdx]);
    st.selDone  = rxDone[ctl.selIdx];
    st.selOk    = rxOk[ctl.selIdx];
    st.selIsCmd = selDec.hit;
    st.selCmd   = selDec.hit ? (NUM_CMDS'(1) << selDec.id) : '0;
    st.rstS     = syncB[3];
    st.pullNS   = syncB[2];
    st.selAS    = syncB[1];
    st.selBS    = syncB[0];
  end

endmodule

// File: rtl/sboot_ctrl.sv
module sboot_ctrl
  import sboot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStat_t               st,
  output dpCtrl_t               ctl,
  output logic                  loadMode,
  output logic                  locked,
  output logic [RATE_SEL_W-1:0] rateIdx,
  output logic [NUM_CMDS-1:0]   cmdStrobe,
  output logic                  errPulse
);

  logic                  armed;
  logic                  hitAny;
  logic [RATE_SEL_W-1:0] hitIdx;

  always_comb begin
    armed  = loadMode & st.selAS & st.selBS;
    hitAny = 1'b0;
    hitIdx = '0;
    // Scan from the top so the lowest index wins a tie.
    for (int k = RATE_COUNT - 1; k >= 0; k--) begin
      if (st.crHit[k]) begin
        hitAny = 1'b1;
        hitIdx = RATE_SEL_W'(k);
      end
    end
    for (int k = 0; k < RATE_COUNT; k++) begin
      ctl.rxEnable[k] = armed & (!locked | (rateIdx == RATE_SEL_W'(k)));
    end
    ctl.selIdx = rateIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadMode  <= 1'b0;
      locked    <= 1'b0;
      rateIdx   <= '0;
      cmdStrobe <= '0;
      errPulse  <= 1'b0;
    end else begin
      cmdStrobe <= '0;
      errPulse  <= 1'b0;
      if (!st.rstS) begin
        loadMode <= 1'b0;
        locked   <= 1'b0;
        rateIdx  <= '0;
      end else begin
        if (!st.pullNS) loadMode <= 1'b1;
        if (loadMode && !locked && hitAny) begin
          locked  <= 1'b1;
          rateIdx <= hitIdx;
        end
        if (locked && st.selDone) begin
          if (st.selOk && st.selIsCmd) cmdStrobe <= st.selCmd;
          else errPulse <= 1'b1;
        end
      end
    end
  end

  // R2: entry only on hold-reset high with boot request low.
  p_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadMode) |-> ($past(st.rstS) && !$past(st.pullNS)));
  // R3: no lock survives outside load mode.
  p_lock_needs_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> loadMode);
  // R6: the locked index does not move.
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> (rateIdx == $past(rateIdx)));
  // R7: at most one strobe, and only from a link that was already locked.
  p_cmd_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStrobe));
  p_cmd_needs_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe != '0) |-> $past(locked));
  // R9: an error never comes with a strobe.
  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (cmdStrobe == '0));

endmodule

// File: rtl/sboot_entry.sv
module sboot_entry
  import sboot_pkg::*;
#(
  parameter int BASE_DIV = 1152
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  holdResetIn,
  input  logic                  bootPullN,
  input  logic                  modeSelA,
  input  logic                  modeSelB,
  input  logic                  serialRx,
  output logic                  loadMode,
  output logic                  rateLocked,
  output logic [RATE_SEL_W-1:0] rateIdx,
  output logic [NUM_CMDS-1:0]   cmdStrobe,
  output logic                  errPulse
);

  dpCtrl_t ctl;
  dpStat_t st;

  sboot_datapath #(.BASE_DIV(BASE_DIV)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .holdResetIn (holdResetIn),
    .bootPullN   (bootPullN),
    .modeSelA    (modeSelA),
    .modeSelB    (modeSelB),
    .serialRx    (serialRx),
    .ctl         (ctl),
    .st          (st)
  );

  sboot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .ctl       (ctl),
    .loadMode  (loadMode),
    .locked    (rateLocked),
    .rateIdx   (rateIdx),
    .cmdStrobe (cmdStrobe),
    .errPulse  (errPulse)
  );

endmodule

// File: tb/sboot_entry_bench.sv
module sboot_entry_bench;

  localparam int BASE = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, holdResetIn = 1'b0, bootPullN = 1'b1;
  logic modeSelA = 1'b1, modeSelB = 1'b1, serialRx = 1'b1;
  logic        loadMode, rateLocked, errPulse;
  logic [1:0]  rateIdx;
  logic [12:0] cmdStrobe;

  sboot_entry #(.BASE_DIV(BASE)) u_sboot_entry (
    .clk(clk), .rstN(rstN), .holdResetIn(holdResetIn), .bootPullN(bootPullN),
    .modeSelA(modeSelA), .modeSelB(modeSelB), .serialRx(serialRx),
    .loadMode(loadMode), .rateLocked(rateLocked), .rateIdx(rateIdx),
    .cmdStrobe(cmdStrobe), .errPulse(errPulse)
  );

  int rateMul[4] = '{1, 4, 8, 32};
  string cmdSet = "CDFGKLPRTUVWZ";

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;

  // Scheduled effects: kind 0 = pin snapshot, kind 1 = framed byte.
  int evCyc[$], evKind[$], evA[$], evB[$];

  bit mRst = 0, mPullN = 1, mSelA = 1, mSelB = 1, mLoad = 0, mLocked = 0;
  int mIdx = 0;
  logic [12:0] expCmd;
  bit expErr;
  bit cmpOn = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int cmdPos(input logic [7:0] v);
    logic [7:0] u;
    u = (v >= "a" && v <= "z") ? v - 8'd32 : v;
    for (int i = 0; i < cmdSet.len(); i++) if (cmdSet[i] == u) return i;
    return -1;
  endfunction

  function automatic void applyEv(input int kind, input int a, input int b);
    int pos;
    if (kind == 0) begin
      {mRst, mPullN, mSelA, mSelB} = a[3:0];
      if (!mRst) begin mLoad = 0; mLocked = 0; mIdx = 0; end
      else if (!mPullN) mLoad = 1;
    end else if (mLoad && mSelA && mSelB) begin
      if (!mLocked) begin
        if (b[8] && b[7:0] == 8'h0D) begin mLocked = 1; mIdx = a; end
      end else if (a == mIdx) begin
        pos = cmdPos(b[7:0]);
        if (!b[8] || pos < 0) expErr = 1'b1;
        else expCmd = 13'(1) << pos;
      end
    end
  endfunction

  always @(negedge clk) begin
    if (cmpOn) begin
      expCmd = '0;
      expErr = 1'b0;
      for (int i = evCyc.size() - 1; i >= 0; i--) begin
        if (evCyc[i] == cyc) begin
          applyEv(evKind[i], evA[i], evB[i]);
          evCyc.delete(i); evKind.delete(i); evA.delete(i); evB.delete(i);
        end
      end
      check(loadMode == mLoad, "R2/R3", "loadMode", loadMode, mLoad);
      check(rateLocked == mLocked, "R6", "rateLocked", rateLocked, mLocked);
      check(rateIdx == mIdx[1:0], "R5/R6", "rateIdx", rateIdx, mIdx);
      check(cmdStrobe == expCmd, "R7/R8", "cmdStrobe", cmdStrobe, expCmd);
      check(errPulse == expErr, "R9/R10", "errPulse", errPulse, expErr);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPins(input bit r, input bit p, input bit a, input bit b);
    @(negedge clk);
    holdResetIn = r; bootPullN = p; modeSelA = a; modeSelB = b;
    evCyc.push_back(cyc + 3); evKind.push_back(0);
    evA.push_back({r, p, a, b}); evB.push_back(0);
  endtask

  task automatic sendFrame(input int k, input logic [7:0] v, input bit stopOk);
    int p;
    p = BASE * rateMul[k];
    @(negedge clk);
    serialRx = 1'b0;
    evCyc.push_back(cyc + 4 + p / 2 + 9 * p); evKind.push_back(1);
    evA.push_back(k); evB.push_back({stopOk, v});
    idle(p);
    for (int j = 0; j < 8; j++) begin
      serialRx = v[j];
      idle(p);
    end
    serialRx = stopOk;
    idle(p);
    serialRx = 1'b1;
    idle(2 * p);
  endtask

  initial begin
    idle(4);
    // R1: reset state
    check(loadMode == 0, "R1", "loadMode", loadMode, 0);
    check(rateLocked == 0, "R1", "rateLocked", rateLocked, 0);
    check(rateIdx == 0, "R1", "rateIdx", rateIdx, 0);
    check(cmdStrobe == 0, "R1", "cmdStrobe", cmdStrobe, 0);
    check(errPulse == 0, "R1", "errPulse", errPulse, 0);
    rstN = 1'b1;
    cmpOn = 1;
    idle(4);

    // R2: hold-reset alone does not enter; carriage return is not heard
    setPins(1, 1, 1, 1); idle(10);
    sendFrame(0, 8'h0D, 1);
    check(loadMode == 0 && rateLocked == 0, "R2", "no entry without boot request", rateLocked, 0);
    setPins(1, 0, 1, 1); idle(6);
    check(loadMode == 1, "R2", "entry", loadMode, 1);
    setPins(1, 1, 1, 1); idle(6);
    check(loadMode == 1, "R2", "held after release", loadMode, 1);

    // R4: one select low disarms hunting
    setPins(1, 1, 1, 0); idle(6);
    sendFrame(1, 8'h0D, 1);
    check(rateLocked == 0, "R4", "no lock with select low", rateLocked, 0);
    setPins(1, 1, 1, 1); idle(6);

    // R6: non-CR before lock is ignored; CR at 1200 locks index 2
    sendFrame(2, "A", 1);
    check(rateLocked == 0, "R6", "lock after non-CR", rateLocked, 0);
    sendFrame(2, 8'h0D, 1);
    check(rateLocked == 1, "R6", "lock at 1200", rateLocked, 1);
    check(rateIdx == 2, "R5", "index for 1200", rateIdx, 2);

    // R7/R8/R9/R10: commands, case, unknown, bad stop
    sendFrame(2, "c", 1);
    sendFrame(2, "D", 1);
    sendFrame(2, "z", 1);
    sendFrame(2, "W", 1);
    sendFrame(2, "l", 1);
    sendFrame(2, "Q", 1);
    sendFrame(2, 8'h0D, 1);
    sendFrame(2, "F", 0);
    idle(8);

    // R3: leaving reset clears everything
    setPins(0, 1, 1, 1); idle(6);
    check(loadMode == 0 && rateLocked == 0 && rateIdx == 0, "R3", "cleared on exit",
          {loadMode, rateLocked, rateIdx}, 0);

    // R5: 300 bps lock gives index 3
    setPins(1, 0, 1, 1); idle(6);
    setPins(1, 1, 1, 1); idle(6);
    sendFrame(3, 8'h0D, 1);
    check(rateIdx == 3 && rateLocked == 1, "R5", "index for 300", rateIdx, 3);
    sendFrame(3, "g", 1);

    // R7: full alphabet at 9600
    setPins(0, 1, 1, 1); idle(6);
    setPins(1, 0, 1, 1); idle(6);
    setPins(1, 1, 1, 1); idle(6);
    sendFrame(0, 8'h0D, 1);
    check(rateIdx == 0 && rateLocked == 1, "R5", "index for 9600", rateIdx, 0);
    for (int i = 0; i < cmdSet.len(); i++) sendFrame(0, cmdSet[i], 1);
    sendFrame(0, "k", 1);
    sendFrame(0, "x", 1);
    idle(20);
    check(evCyc.size() == 0, "R6", "pending events", evCyc.size(), 0);

    cmpOn = 0;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule